// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control registers of a small processor core and serves one read port and one write port. Each port has its own register index. The status register packs three things into one word: the current status byte, the saved copy of that byte taken on exception entry, and the condition flag. A register with its own index holds the condition flag alone. Other registers hold a second-level saved status byte, two saved program counters and two general 32-bit scratch words.

The block also banks the stack pointer. The general register file keeps the live stack pointer, and this block keeps a saved copy for interrupt mode and a saved copy for user mode. Bit 7 of the status byte selects the stack mode. Accesses to the interrupt or user stack-pointer index go either to the live pointer or to the saved copy, depending on that bit. A status write that flips the bit swaps the live pointer with the saved copy in the same cycle. The block drives the new live value to the general register file on `sp_we_o`/`sp_wdata_o`, and that file captures it on the same clock edge.

Reads are combinational from the current register state. A write takes effect at the rising clock edge. The active-low reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `ctrl_reg_bank`

## Requirements
- R1: While reset is active and after it is released, every register reads zero and the stack mode is clear. Write requests made during reset change nothing and raise no live stack-pointer write.
- R2: Reading index 0 (status) returns the saved status byte ANDed with 0xC1 in bits 15:8, the status byte ANDed with 0xC0 in bits 7:0 with the condition flag in bit 0, and zero in bits 31:16.
- R3: A write to index 0 loads data bits 15:8 into the saved status byte, loads bits 7:0 into the status byte, and loads bit 0 into the condition flag.
- R4: A write to index 0 whose bit 7 differs from the current stack-mode bit raises `sp_we_o` in that cycle. Going from clear to set, the live pointer is stored into the interrupt copy and `sp_wdata_o` carries the user copy. Going from set to clear, the live pointer is stored into the user copy and `sp_wdata_o` carries the interrupt copy. A status write that keeps the mode raises no live write.
- R5: Index 2 (interrupt stack pointer) reads and writes the live pointer while the mode is clear, and the stored interrupt copy while the mode is set.
- R6: Index 3 (user stack pointer) reads and writes the live pointer while the mode is set, and the stored user copy while the mode is clear.
- R7: Index 6 and index 8 (the two saved program counters) store all 32 bits on write and read back with bit 0 forced to zero.
- R8: Index 7 (second-level saved status) stores data bits 7:0 on write and reads back that byte ANDed with 0xC1.
- R9: Index 1 reads the condition flag in bit 0 and zero in every other bit. A write to it changes only the condition flag.
- R10: Indices 4 and 5 are plain 32-bit storage that reads back exactly what was written.
- R11: Reads of indices 9 to 15 return zero. Writes to them change no register and raise no live stack-pointer write.
- R12: When the read index equals the write index in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Register index of the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 4 | Register index of the read |
| rd_data | output | 32 | Read data, combinational |
| sp_live_i | input | 32 | Current live stack pointer from the general register file |
| sp_we_o | output | 1 | Live stack-pointer write strobe |
| sp_wdata_o | output | 32 | New live stack-pointer value |

## Verification
Two functions can meet in one cycle: a status write that flips the stack mode (and so swaps and writes the live pointer), and a read of a stack-pointer index or of the status register itself. Reading the status register in the cycle of its own write should show the old byte. The vector table provokes this with flipping writes in both directions while the read port points at the status index. It then reads the interrupt and user indices in the following cycles, with the live pointer input changed each time, so the bench can tell the live pointer from the saved copies. The live write strobe and its data are judged in the write cycle itself. The next cycle's reads are checked against the copy that should have been saved.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int DATA_W    = 32;
  localparam int IDX_W     = 4;
  localparam int BYTE_W    = 8;
  localparam int MODE_BIT  = 7;

  // register index map
  localparam logic [IDX_W-1:0] CR_STATUS = 4'd0;
  localparam logic [IDX_W-1:0] CR_COND   = 4'd1;
  localparam logic [IDX_W-1:0] CR_ISP    = 4'd2;
  localparam logic [IDX_W-1:0] CR_USP    = 4'd3;
  localparam logic [IDX_W-1:0] CR_SCR0   = 4'd4;
  localparam logic [IDX_W-1:0] CR_SCR1   = 4'd5;
  localparam logic [IDX_W-1:0] CR_BPC    = 4'd6;
  localparam logic [IDX_W-1:0] CR_BBSTAT = 4'd7;
  localparam logic [IDX_W-1:0] CR_BBPC   = 4'd8;
  localparam logic [IDX_W-1:0] CR_LAST   = CR_BBPC;

  // read masks
  localparam logic [BYTE_W-1:0] SAVED_RD_MASK = 8'hC1;
  localparam logic [BYTE_W-1:0] LIVE_RD_MASK  = 8'hC0;
endpackage

// File: rtl/crf_rst_sync.sv
module crf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/crf_status_unit.sv
module crf_status_unit
  import crf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          mode_q,
  output logic [DW-1:0] status_rd,
  output logic [DW-1:0] cond_rd,
  output logic [DW-1:0] bbstat_rd
);
  logic [BYTE_W-1:0] stat_q, stat_d;
  logic [BYTE_W-1:0] bstat_q, bstat_d;
  logic [BYTE_W-1:0] bbstat_q, bbstat_d;
  logic              cond_q, cond_d;
  logic              ld_stat, ld_cond, ld_bbstat;

  // next state
  always_comb begin
    ld_stat   = wr_en && (wr_idx == CR_STATUS);
    ld_cond   = wr_en && ((wr_idx == CR_STATUS) || (wr_idx == CR_COND));
    ld_bbstat = wr_en && (wr_idx == CR_BBSTAT);
    stat_d    = wr_data[BYTE_W-1:0];
    bstat_d   = wr_data[2*BYTE_W-1:BYTE_W];
    cond_d    = wr_data[0];
    bbstat_d  = wr_data[BYTE_W-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= '0;
      bstat_q  <= '0;
      bbstat_q <= '0;
      cond_q   <= 1'b0;
    end else begin
      if (ld_stat) begin
        stat_q  <= stat_d;
        bstat_q <= bstat_d;
      end
      if (ld_cond)   cond_q   <= cond_d;
      if (ld_bbstat) bbstat_q <= bbstat_d;
    end
  end

  assign mode_q = stat_q[MODE_BIT];

  always_comb begin
    status_rd = '0;
    status_rd[2*BYTE_W-1:BYTE_W] = bstat_q & SAVED_RD_MASK;
    status_rd[BYTE_W-1:0]        = (stat_q & LIVE_RD_MASK) | {{(BYTE_W-1){1'b0}}, cond_q};
    cond_rd      = '0;
    cond_rd[0]   = cond_q;
    bbstat_rd    = '0;
    bbstat_rd[BYTE_W-1:0] = bbstat_q & SAVED_RD_MASK;
  end

  // R9: a flag-only write leaves both status bytes alone
  p_cond_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == CR_COND) |=>
      (stat_q == $past(stat_q)) && (bstat_q == $past(bstat_q)) && (cond_q == $past(wr_data[0])));

  // R3: a status write lands in all three fields
  p_status_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == CR_STATUS) |=>
      (stat_q == $past(wr_data[7:0])) && (bstat_q == $past(wr_data[15:8])) && (cond_q == $past(wr_data[0])));
endmodule

// File: rtl/crf_stack_bank.sv
module crf_stack_bank
  import crf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          mode_q,
  input  logic [DW-1:0] sp_live_i,
  output logic [DW-1:0] isp_rd,
  output logic [DW-1:0] usp_rd,
  output logic          sp_we,
  output logic [DW-1:0] sp_wdata
);
  logic [DW-1:0] isp_q, isp_d, usp_q, usp_d;
  logic          ld_isp, ld_usp;
  logic          status_wr, flip;

  // next state
  always_comb begin
    status_wr = rst_n && wr_en && (wr_idx == CR_STATUS);
    flip      = status_wr && (wr_data[MODE_BIT] != mode_q);
    isp_d     = isp_q;
    usp_d     = usp_q;
    ld_isp    = 1'b0;
    ld_usp    = 1'b0;
    sp_we     = 1'b0;
    sp_wdata  = '0;
    if (flip) begin
      sp_we = 1'b1;
      if (mode_q) begin
        usp_d    = sp_live_i;
        ld_usp   = 1'b1;
        sp_wdata = isp_q;
      end else begin
        isp_d    = sp_live_i;
        ld_isp   = 1'b1;
        sp_wdata = usp_q;
      end
    end else if (rst_n && wr_en && (wr_idx == CR_ISP)) begin
      if (mode_q) begin
        isp_d  = wr_data;
        ld_isp = 1'b1;
      end else begin
        sp_we    = 1'b1;
        sp_wdata = wr_data;
      end
    end else if (rst_n && wr_en && (wr_idx == CR_USP)) begin
      if (mode_q) begin
        sp_we    = 1'b1;
        sp_wdata = wr_data;
      end else begin
        usp_d  = wr_data;
        ld_usp = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isp_q <= '0;
      usp_q <= '0;
    end else begin
      if (ld_isp) isp_q <= isp_d;
      if (ld_usp) usp_q <= usp_d;
    end
  end

  assign isp_rd = mode_q ? isp_q : sp_live_i;
  assign usp_rd = mode_q ? sp_live_i : usp_q;

  // R4: entering interrupt mode saves the live pointer into the interrupt copy
  p_swap_to_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && !mode_q && wr_data[MODE_BIT]) |=> (isp_q == $past(sp_live_i)) && mode_q);

  // R4: leaving interrupt mode saves the live pointer into the user copy
  p_swap_to_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && mode_q && !wr_data[MODE_BIT]) |=> (usp_q == $past(sp_live_i)) && !mode_q);

  // R4: a status write that keeps the mode never touches the live pointer
  p_keep_mode_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && (wr_data[MODE_BIT] == mode_q)) |-> !sp_we);

  // R5: an interrupt-pointer write in clear mode leaves the saved copy alone
  p_isp_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == CR_ISP && !mode_q) |=> $stable(isp_q));
endmodule

// File: rtl/crf_word_reg.sv
module crf_word_reg
  import crf_pkg::*;
#(
  parameter int          DW     = DATA_W,
  parameter int          IW     = IDX_W,
  parameter logic [IW-1:0] MY_IDX = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] word_q
);
  logic          ld;
  logic [DW-1:0] word_d;

  always_comb begin
    ld     = wr_en && (wr_idx == MY_IDX);
    word_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= '0;
    else if (ld) word_q <= word_d;
  end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import crf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] sp_live_i,
  output logic          sp_we_o,
  output logic [DW-1:0] sp_wdata_o
);
  localparam int NWORDS = 4;
  localparam logic [IW-1:0] WORD_IDX [NWORDS] = '{CR_SCR0, CR_SCR1, CR_BPC, CR_BBPC};

  logic          core_rst_n;
  logic          mode_q;
  logic [DW-1:0] status_rd, cond_rd, bbstat_rd, isp_rd, usp_rd;
  logic [DW-1:0] word_q [NWORDS];
  logic [DW-1:0] pc_lsb_clr;

  crf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  crf_status_unit #(.DW(DW), .IW(IW)) u_status (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .mode_q    (mode_q),
    .status_rd (status_rd),
    .cond_rd   (cond_rd),
    .bbstat_rd (bbstat_rd)
  );

  crf_stack_bank #(.DW(DW), .IW(IW)) u_stack (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .mode_q    (mode_q),
    .sp_live_i (sp_live_i),
    .isp_rd    (isp_rd),
    .usp_rd    (usp_rd),
    .sp_we     (sp_we_o),
    .sp_wdata  (sp_wdata_o)
  );

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    crf_word_reg #(.DW(DW), .IW(IW), .MY_IDX(WORD_IDX[g])) u_word (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .word_q  (word_q[g])
    );
  end

  assign pc_lsb_clr = {{(DW-1){1'b1}}, 1'b0};

  // read mux
  always_comb begin
    case (rd_idx)
      CR_STATUS: rd_data = status_rd;
      CR_COND:   rd_data = cond_rd;
      CR_ISP:    rd_data = isp_rd;
      CR_USP:    rd_data = usp_rd;
      CR_SCR0:   rd_data = word_q[0];
      CR_SCR1:   rd_data = word_q[1];
      CR_BPC:    rd_data = word_q[2] & pc_lsb_clr;
      CR_BBSTAT: rd_data = bbstat_rd;
      CR_BBPC:   rd_data = word_q[3] & pc_lsb_clr;
      default:   rd_data = '0;
    endcase
  end

  // R7: saved program counters never read back an odd value
  p_pc_even_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rd_idx == CR_BPC || rd_idx == CR_BBPC) |-> (rd_data[0] == 1'b0));

  // R2: status word keeps its unused bits at zero
  p_status_holes_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rd_idx == CR_STATUS) |-> (rd_data[DW-1:16] == '0) && (rd_data[13:9] == '0) && (rd_data[5:1] == '0));

  // R11: undefined indices stay silent
  p_undef_quiet_r11: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && wr_idx > CR_LAST) |-> !sp_we_o);

  p_undef_read_r11: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rd_idx > CR_LAST) |-> (rd_data == '0));

  // R1: no live write while the core is held in reset
  always_comb begin
    if (!core_rst_n) p_reset_quiet_r1: assert (!sp_we_o);
  end
endmodule

// File: tb/ctrl_reg_bank_test.sv
module ctrl_reg_bank_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [3:0]  wi;
    logic [31:0] wd;
    logic [3:0]  ri;
    logic [31:0] sp;
    logic [31:0] erd;
    logic        ewe;
    logic [31:0] ewd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 35;
  // Model starts from reset: all zero, stack mode clear.
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0, 32'h0,         4'd0, 32'h0,         32'h0,         1'b0, 32'h0,         4'd1},  // R1 status zero
    '{1'b1, 4'd4, 32'hDEADBEEF,  4'd4, 32'h0,         32'h0,         1'b0, 32'h0,         4'd12}, // R12 old value
    '{1'b0, 4'd0, 32'h0,         4'd4, 32'h0,         32'hDEADBEEF,  1'b0, 32'h0,         4'd10}, // R10
    '{1'b1, 4'd5, 32'h12345678,  4'd5, 32'h0,         32'h0,         1'b0, 32'h0,         4'd12}, // R12
    '{1'b0, 4'd0, 32'h0,         4'd5, 32'h0,         32'h12345678,  1'b0, 32'h0,         4'd10}, // R10
    '{1'b1, 4'd6, 32'h00001235,  4'd6, 32'h0,         32'h0,         1'b0, 32'h0,         4'd12}, // R12
    '{1'b0, 4'd0, 32'h0,         4'd6, 32'h0,         32'h00001234,  1'b0, 32'h0,         4'd7},  // R7 bit0 cleared
    '{1'b1, 4'd8, 32'hFFFFFFFF,  4'd8, 32'h0,         32'h0,         1'b0, 32'h0,         4'd12}, // R12
    '{1'b0, 4'd0, 32'h0,         4'd8, 32'h0,         32'hFFFFFFFE,  1'b0, 32'h0,         4'd7},  // R7
    '{1'b1, 4'd7, 32'hABCDFFFF,  4'd7, 32'h0,         32'h0,         1'b0, 32'h0,         4'd12}, // R12
    '{1'b0, 4'd0, 32'h0,         4'd7, 32'h0,         32'h000000C1,  1'b0, 32'h0,         4'd8},  // R8
    '{1'b1, 4'd0, 32'h0000FF3F,  4'd0, 32'h0,         32'h0,         1'b0, 32'h0,         4'd12}, // R12, no flip
    '{1'b0, 4'd0, 32'h0,         4'd0, 32'h0,         32'h0000C101,  1'b0, 32'h0,         4'd2},  // R2 R3
    '{1'b1, 4'd1, 32'hFFFFFFFE,  4'd1, 32'h0,         32'h00000001,  1'b0, 32'h0,         4'd9},  // R9 old flag
    '{1'b0, 4'd0, 32'h0,         4'd0, 32'h0,         32'h0000C100,  1'b0, 32'h0,         4'd9},  // R9 only flag changed
    '{1'b0, 4'd0, 32'h0,         4'd1, 32'h0,         32'h0,         1'b0, 32'h0,         4'd9},  // R9
    '{1'b1, 4'd2, 32'h11110000,  4'd2, 32'hAAAA0000,  32'hAAAA0000,  1'b1, 32'h11110000,  4'd5},  // R5 live in clear mode
    '{1'b1, 4'd3, 32'h22220000,  4'd3, 32'hAAAA0000,  32'h0,         1'b0, 32'h0,         4'd6},  // R6 slot in clear mode
    '{1'b0, 4'd0, 32'h0,         4'd3, 32'hAAAA0000,  32'h22220000,  1'b0, 32'h0,         4'd6},  // R6
    '{1'b1, 4'd0, 32'h00000080,  4'd0, 32'h55550000,  32'h0000C100,  1'b1, 32'h22220000,  4'd4},  // R4 clear->set
    '{1'b0, 4'd0, 32'h0,         4'd0, 32'h22220000,  32'h00000080,  1'b0, 32'h0,         4'd3},  // R3
    '{1'b0, 4'd0, 32'h0,         4'd2, 32'h22220000,  32'h55550000,  1'b0, 32'h0,         4'd4},  // R4 saved copy
    '{1'b0, 4'd0, 32'h0,         4'd3, 32'h77770000,  32'h77770000,  1'b0, 32'h0,         4'd6},  // R6 live in set mode
    '{1'b1, 4'd3, 32'h33330000,  4'd2, 32'h77770000,  32'h55550000,  1'b1, 32'h33330000,  4'd6},  // R6 live write
    '{1'b1, 4'd2, 32'h44440000,  4'd2, 32'h33330000,  32'h55550000,  1'b0, 32'h0,         4'd5},  // R5 slot in set mode
    '{1'b0, 4'd0, 32'h0,         4'd2, 32'h33330000,  32'h44440000,  1'b0, 32'h0,         4'd5},  // R5
    '{1'b1, 4'd0, 32'h00000081,  4'd1, 32'h33330000,  32'h0,         1'b0, 32'h0,         4'd4},  // R4 keep mode
    '{1'b0, 4'd0, 32'h0,         4'd1, 32'h33330000,  32'h00000001,  1'b0, 32'h0,         4'd9},  // R9
    '{1'b1, 4'd0, 32'h00000040,  4'd0, 32'h99990000,  32'h00000081,  1'b1, 32'h44440000,  4'd4},  // R4 set->clear
    '{1'b0, 4'd0, 32'h0,         4'd3, 32'h44440000,  32'h99990000,  1'b0, 32'h0,         4'd4},  // R4 user copy
    '{1'b0, 4'd0, 32'h0,         4'd0, 32'h44440000,  32'h00000040,  1'b0, 32'h0,         4'd2},  // R2
    '{1'b1, 4'd9, 32'hFFFFFFFF,  4'd9, 32'h44440000,  32'h0,         1'b0, 32'h0,         4'd11}, // R11
    '{1'b1, 4'd15,32'hFFFFFFFF,  4'd15,32'h44440000,  32'h0,         1'b0, 32'h0,         4'd11}, // R11
    '{1'b0, 4'd0, 32'h0,         4'd4, 32'h44440000,  32'hDEADBEEF,  1'b0, 32'h0,         4'd11}, // R11 storage intact
    '{1'b0, 4'd0, 32'h0,         4'd0, 32'h44440000,  32'h00000040,  1'b0, 32'h0,         4'd11}  // R11 status intact
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic [3:0]  rd_idx;
  logic [31:0] rd_data;
  logic [31:0] sp_live_i;
  logic        sp_we_o;
  logic [31:0] sp_wdata_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_reg_bank uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .sp_live_i  (sp_live_i),
    .sp_we_o    (sp_we_o),
    .sp_wdata_o (sp_wdata_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [3:0] wi, input logic [31:0] wd,
                       input logic [3:0] ri, input logic [31:0] sp);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd; rd_idx = ri; sp_live_i = sp;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0; sp_live_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // main vector walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].we, VECS[i].wi, VECS[i].wd, VECS[i].ri, VECS[i].sp);
      check($sformatf("R%0d vec %0d rd_data", VECS[i].rq, i), rd_data, VECS[i].erd);
      check($sformatf("R%0d vec %0d sp_we", VECS[i].rq, i), {31'b0, sp_we_o}, {31'b0, VECS[i].ewe});
      if (VECS[i].ewe)
        check($sformatf("R%0d vec %0d sp_wdata", VECS[i].rq, i), sp_wdata_o, VECS[i].ewd);
    end

    // R1: reset clears registers asynchronously
    @(negedge clk);
    rst_n = 1'b0;
    drive(1'b0, 4'd0, 32'h0, 4'd0, 32'hCAFE0000);
    check("R1 status after reset", rd_data, 32'h0);
    drive(1'b0, 4'd0, 32'h0, 4'd4, 32'hCAFE0000);
    check("R1 scratch after reset", rd_data, 32'h0);
    drive(1'b0, 4'd0, 32'h0, 4'd2, 32'hCAFE0000);
    check("R1 mode clear, isp reads live", rd_data, 32'hCAFE0000);
    drive(1'b1, 4'd2, 32'h12121212, 4'd3, 32'hCAFE0000);
    check("R1 no live write in reset", {31'b0, sp_we_o}, 32'h0);
    check("R1 usp slot zero", rd_data, 32'h0);
    drive(1'b1, 4'd4, 32'h5A5A5A5A, 4'd4, 32'hCAFE0000);
    drive(1'b0, 4'd0, 32'h0, 4'd4, 32'hCAFE0000);
    check("R1 write ignored in reset", rd_data, 32'h0);

    // R1: writes work again after synchronized release
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1'b1, 4'd5, 32'h0BADF00D, 4'd5, 32'h0);
    drive(1'b0, 4'd0, 32'h0, 4'd5, 32'h0);
    check("R1 write after release", rd_data, 32'h0BADF00D);

    // R7: even value stored intact
    drive(1'b1, 4'd8, 32'h80000002, 4'd0, 32'h0);
    drive(1'b0, 4'd0, 32'h0, 4'd8, 32'h0);
    check("R7 even pc kept", rd_data, 32'h80000002);

    // R4: flip into set mode right after reset, user copy is zero
    drive(1'b1, 4'd0, 32'h000000C0, 4'd2, 32'h0F0F0000);
    check("R4 flip after reset sp_we", {31'b0, sp_we_o}, 32'h1);
    check("R4 flip after reset sp_wdata", sp_wdata_o, 32'h0);
    check("R5 isp read before flip lands", rd_data, 32'h0F0F0000);
    drive(1'b0, 4'd0, 32'h0, 4'd0, 32'h0);
    check("R2 status C0 mask", rd_data, 32'h000000C0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule